// File: doc/BRIEF.md
# Two-Bank Interleaved Pipelined Cache Controller

The block fronts a large unified cache that is split into two independent banks. The lowest address bit of a doubleword address picks the bank (0 even, 1 odd). Two request ports are offered every cycle. Requests to different banks are both accepted and served side by side. When both target the same bank, port 0 goes ahead and port 1 is held off for that cycle. Each bank has its own one-way write data path into its synchronous data RAM and its own one-way read data path out of it. Because of this, reads and writes can follow each other in any mix, every cycle, with no idle cycle between them.

Tags are four-way set associative. A line covers one even and one odd doubleword that share a set index and tag. Each bank owns an identical copy of the whole tag store, so both banks can do a lookup in the same cycle. The tag compare picks the way first, and only that one way of the data RAM is then read or written.

Every accepted access moves through five fixed stages: address capture for the tag store, tag lookup and way select, transfer of the chosen way towards the data RAM, data RAM access, and response. A miss cancels the data RAM access and comes back as a miss response in the same slot a hit would use. A small install port writes a tag into a chosen way of a set, in both copies. Refill from main memory and coherence are handled elsewhere.

Top module: `dual_bank_cache`

## Requirements
- R1: Address bit 0 selects the bank, bits SET_W:1 form the set index and the bits above form the tag; the two doublewords of one line are stored separately.
- R2: Two valid requests whose address bit 0 differs are both accepted in the same cycle (req_rdy = 2'b11) and both complete.
- R3: Port 0 is always ready; when both ports are valid with equal address bit 0, req_rdy[1] is 0 that cycle and port 1's request is not performed until presented again.
- R4: A request accepted at a clock edge produces exactly one response on its own port, visible after the fifth rising edge counting the accepting edge; rsp_wr repeats the request's write flag; responses on a port keep request order.
- R5: A read that hits returns the data of the most recent write hit to the same address.
- R6: A lookup that finds no valid matching tag gives rsp_hit = 0 and rsp_data = 0; a write miss leaves the data RAM unchanged.
- R7: A bank accepts one access per cycle in any read/write sequence with no idle cycle; a read accepted the cycle after a write to the same address returns the new data.
- R8: An install writes tag ins_tag into way ins_way of set ins_set with valid set; any other way of that set holding the same tag becomes invalid; data stored in a way is kept across installs.
- R9: After reset no response is valid, both ports are ready, all tags are invalid and all data words read as zero.
- R10: The four ways of a set hold four different tags at once, each hitting on its own data; a lookup never matches more than one way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, shared with the data RAMs |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 2 | Request valid, one bit per port |
| req_wr | input | 2 | 1 write, 0 read, per port |
| req_addr | input | 2 x (1+SET_W+TAG_W) | Doubleword address per port |
| req_wdata | input | 2 x DATA_W | Write data per port |
| req_rdy | output | 2 | Request accepted this cycle, per port |
| rsp_vld | output | 2 | Response valid, per port |
| rsp_hit | output | 2 | Response found the tag |
| rsp_wr | output | 2 | Response belongs to a write |
| rsp_data | output | 2 x DATA_W | Read data, zero for misses and writes |
| ins_vld | input | 1 | Tag install strobe |
| ins_set | input | SET_W | Set written by an install |
| ins_tag | input | TAG_W | Tag written by an install |
| ins_way | input | 2 | Way written by an install |

## Verification
The bench builds the block with SET_W = 2 and TAG_W = 3. This gives only 64 doubleword addresses and 16 tag slots, so every address can be written and read back, in both port orders. It also means every way of every set gets filled, and half of all tags stay absent, so misses appear all over the address space. The small space also allows a full sweep of same-bank collisions. Tags can be moved between ways and then checked against an arithmetic model of tags and data.

// File: rtl/dual_bank_cache.sv
module dual_bank_cache #(
  parameter int SET_W  = 4,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 64,
  localparam int ADDR_W = 1 + SET_W + TAG_W,
  localparam int WAYS   = 4,
  localparam int SETS   = 1 << SET_W,
  localparam int LINES  = SETS * WAYS
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [1:0]                   req_vld,
  input  logic [1:0]                   req_wr,
  input  logic [1:0][ADDR_W-1:0]       req_addr,
  input  logic [1:0][DATA_W-1:0]       req_wdata,
  output logic [1:0]                   req_rdy,
  output logic [1:0]                   rsp_vld,
  output logic [1:0]                   rsp_hit,
  output logic [1:0]                   rsp_wr,
  output logic [1:0][DATA_W-1:0]       rsp_data,
  input  logic                         ins_vld,
  input  logic [SET_W-1:0]             ins_set,
  input  logic [TAG_W-1:0]             ins_tag,
  input  logic [1:0]                   ins_way
);

  logic [TAG_W-1:0] tag_q  [2][SETS][WAYS];
  logic             tval_q [2][SETS][WAYS];

  logic [1:0]        o_v4, o_p4, o_w4, o_h4;
  logic [DATA_W-1:0] o_d4 [2];
  logic [2:0]        age_q;

  // R3: port 0 always wins a bank collision
  assign req_rdy[0] = 1'b1;
  assign req_rdy[1] = !(req_vld[0] && req_vld[1] && (req_addr[0][0] == req_addr[1][0]));

  // R8: install writes both tag copies identically
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++)
        for (int s = 0; s < SETS; s++)
          for (int w = 0; w < WAYS; w++) begin
            tag_q[b][s][w]  <= '0;
            tval_q[b][s][w] <= 1'b0;
          end
    end else if (ins_vld) begin
      for (int b = 0; b < 2; b++)
        for (int w = 0; w < WAYS; w++) begin
          if (w == int'(ins_way)) begin
            tag_q[b][ins_set][w]  <= ins_tag;
            tval_q[b][ins_set][w] <= 1'b1;
          end else if (tag_q[b][ins_set][w] == ins_tag) begin
            tval_q[b][ins_set][w] <= 1'b0;
          end
        end
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic              tk0, tk1;
    logic [ADDR_W-1:0] sel_addr;
    logic              v1, v2, v3;
    logic              p1, p2, p3;
    logic              w1, w2, w3;
    logic [SET_W-1:0]  s1, s2, s3;
    logic [TAG_W-1:0]  t1;
    logic [DATA_W-1:0] d1, d2, d3;
    logic              h2, h3;
    logic [1:0]        y2, y3;
    logic [WAYS-1:0]   hv;
    logic [1:0]        hway;
    logic [SET_W+1:0]  line;
    logic [DATA_W-1:0] wbus, rbus;
    logic [DATA_W-1:0] mem_q [LINES];
    logic              v4, p4, w4, h4;
    logic [DATA_W-1:0] d4;

    // R1: bank chosen by the lowest address bit
    assign tk0 = req_vld[0] && (req_addr[0][0] == 1'(b));
    assign tk1 = req_vld[1] && (req_addr[1][0] == 1'(b)) && !tk0;
    assign sel_addr = tk1 ? req_addr[1] : req_addr[0];

    // stage 1: address towards the tag store
    always_ff @(posedge clk) begin
      if (!rst_n) v1 <= 1'b0;
      else        v1 <= tk0 || tk1;
      p1 <= tk1;
      w1 <= tk1 ? req_wr[1] : req_wr[0];
      s1 <= sel_addr[SET_W:1];
      t1 <= sel_addr[ADDR_W-1:SET_W+1];
      d1 <= tk1 ? req_wdata[1] : req_wdata[0];
    end

    // stage 2: tag compare on this bank's copy, way chosen after compare
    always_comb begin
      for (int w = 0; w < WAYS; w++)
        hv[w] = tval_q[b][s1][w] && (tag_q[b][s1][w] == t1);
      hway = '0;
      for (int w = 0; w < WAYS; w++)
        if (hv[w]) hway = 2'(w);
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v2 <= 1'b0;
        v3 <= 1'b0;
      end else begin
        v2 <= v1;
        v3 <= v2;
      end
      p2 <= p1; w2 <= w1; s2 <= s1; d2 <= d1; h2 <= |hv; y2 <= hway;
      p3 <= p2; w3 <= w2; s3 <= s2; d3 <= d2; h3 <= h2; y3 <= y2;
    end

    // stage 4: synchronous data RAM, separate write and read paths
    assign line = {s3, y3};
    assign wbus = d3;
    assign rbus = mem_q[line];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < LINES; i++) mem_q[i] <= '0;
      end else if (v3 && w3 && h3) begin
        mem_q[line] <= wbus;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) v4 <= 1'b0;
      else        v4 <= v3;
      p4 <= p3;
      w4 <= w3;
      h4 <= h3;
      d4 <= (v3 && !w3 && h3) ? rbus : '0;
    end

    assign o_v4[b] = v4;
    assign o_p4[b] = p4;
    assign o_w4[b] = w4;
    assign o_h4[b] = h4;
    assign o_d4[b] = d4;

    a_r10_single_way: assert property (@(posedge clk) disable iff (!rst_n)
      v1 |-> $onehot0(hv));
  end

  // stage 5: return to the issuing port
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_vld  <= '0;
      rsp_hit  <= '0;
      rsp_wr   <= '0;
      rsp_data <= '0;
    end else begin
      for (int p = 0; p < 2; p++) begin
        if (o_v4[0] && (o_p4[0] == 1'(p))) begin
          rsp_vld[p] <= 1'b1; rsp_hit[p] <= o_h4[0];
          rsp_wr[p]  <= o_w4[0]; rsp_data[p] <= o_d4[0];
        end else if (o_v4[1] && (o_p4[1] == 1'(p))) begin
          rsp_vld[p] <= 1'b1; rsp_hit[p] <= o_h4[1];
          rsp_wr[p]  <= o_w4[1]; rsp_data[p] <= o_d4[1];
        end else begin
          rsp_vld[p] <= 1'b0; rsp_hit[p] <= 1'b0;
          rsp_wr[p]  <= 1'b0; rsp_data[p] <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              age_q <= '0;
    else if (age_q != 3'd5)  age_q <= age_q + 3'd1;
  end

  a_r2_one_slot_per_port: assert property (@(posedge clk) disable iff (!rst_n)
    !(o_v4 == 2'b11 && o_p4[0] == o_p4[1]));

  for (genvar g = 0; g < 2; g++) begin : g_chk
    a_r4_rsp_has_request: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q == 3'd5) && rsp_vld[g] |-> $past(req_vld[g] && req_rdy[g], 5));
    a_r4_request_has_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q == 3'd5) && $past(req_vld[g] && req_rdy[g], 5) |-> rsp_vld[g]);
    a_r4_kind_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q == 3'd5) && rsp_vld[g] |-> rsp_wr[g] == $past(req_wr[g], 5));
    a_r6_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_vld[g] && !rsp_hit[g] |-> rsp_data[g] == '0);
  end

endmodule

// File: tb/test_dual_bank_cache.sv
module test_dual_bank_cache;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       req_vld = '0;
  logic [1:0]       req_wr = '0;
  logic [1:0][5:0]  req_addr = '0;
  logic [1:0][63:0] req_wdata = '0;
  logic [1:0]       req_rdy;
  logic [1:0]       rsp_vld, rsp_hit, rsp_wr;
  logic [1:0][63:0] rsp_data;
  logic             ins_vld = 1'b0;
  logic [1:0]       ins_set = '0;
  logic [2:0]       ins_tag = '0;
  logic [1:0]       ins_way = '0;

  dual_bank_cache #(.SET_W(2), .TAG_W(3), .DATA_W(64)) i_dual_bank_cache (
    .clk(clk), .rst_n(rst_n),
    .req_vld(req_vld), .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_rdy(req_rdy),
    .rsp_vld(rsp_vld), .rsp_hit(rsp_hit), .rsp_wr(rsp_wr), .rsp_data(rsp_data),
    .ins_vld(ins_vld), .ins_set(ins_set), .ins_tag(ins_tag), .ins_way(ins_way));

  always #5 clk = ~clk;

  typedef struct packed {
    logic        wr;
    logic        hit;
    logic [63:0] data;
    logic [31:0] cyc;
  } exp_t;

  exp_t  eq0[$], eq1[$];
  string rq0[$], rq1[$];
  int    nchk = 0, nfail = 0, cyc = 0;
  bit    done = 1'b0;

  logic [2:0]  mtag [4][4];
  bit          mval [4][4];
  logic [63:0] mdat [2][4][4];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [63:0] pat(input logic [5:0] a, input int k);
    return 64'h9E37_79B9_7F4A_7C15 * (64'(a) + 64'd1) + 64'(k);
  endfunction

  function automatic logic [5:0] mk(input int tag, input int set, input int bank);
    return {3'(tag), 2'(set), 1'(bank)};
  endfunction

  task automatic model(input int p, input bit w, input logic [5:0] a,
                       input logic [63:0] d, input string rq);
    exp_t e;
    int s = int'(a[2:1]);
    e.hit = 1'b0; e.wr = w; e.data = '0; e.cyc = 32'(cyc);
    for (int k = 0; k < 4; k++)
      if (mval[s][k] && mtag[s][k] == a[5:3]) begin
        e.hit = 1'b1;
        if (w) mdat[a[0]][s][k] = d;
        else   e.data = mdat[a[0]][s][k];
      end
    if (p == 0) begin eq0.push_back(e); rq0.push_back(rq); end
    else        begin eq1.push_back(e); rq1.push_back(rq); end
  endtask

  task automatic drive(input bit v0, input bit w0, input logic [5:0] a0, input logic [63:0] d0,
                       input bit v1, input bit w1, input logic [5:0] a1, input logic [63:0] d1,
                       input string rq);
    bit e1;
    req_vld = {v1, v0}; req_wr = {w1, w0};
    req_addr[0] = a0; req_addr[1] = a1;
    req_wdata[0] = d0; req_wdata[1] = d1;
    #1;
    e1 = !(v0 && v1 && (a0[0] == a1[0]));
    nchk++;
    if (req_rdy !== {e1, 1'b1}) begin
      nfail++;
      $display("FAIL %s/R3 ready: actual=%b expected=%b", rq, req_rdy, {e1, 1'b1});
    end
    if (v0) model(0, w0, a0, d0, rq);
    if (v1 && e1) model(1, w1, a1, d1, rq);
    @(posedge clk); @(negedge clk);
    req_vld = '0;
  endtask

  task automatic install(input int s, input int t, input int w);
    ins_vld = 1'b1; ins_set = 2'(s); ins_tag = 3'(t); ins_way = 2'(w);
    for (int k = 0; k < 4; k++)
      if (k == w) begin mtag[s][k] = 3'(t); mval[s][k] = 1'b1; end
      else if (mtag[s][k] == 3'(t)) mval[s][k] = 1'b0;
    @(posedge clk); @(negedge clk);
    ins_vld = 1'b0;
  endtask

  task automatic take(input int p);
    exp_t  e;
    string rq;
    if ((p == 0 && eq0.size() == 0) || (p == 1 && eq1.size() == 0)) begin
      nchk++; nfail++;
      $display("FAIL R4 port%0d: actual=unexpected response expected=none", p);
      return;
    end
    if (p == 0) begin e = eq0.pop_front(); rq = rq0.pop_front(); end
    else        begin e = eq1.pop_front(); rq = rq1.pop_front(); end
    nchk++;
    if (rsp_wr[p] !== e.wr || rsp_hit[p] !== e.hit || rsp_data[p] !== e.data ||
        cyc != int'(e.cyc) + 5) begin
      nfail++;
      $display("FAIL %s/R4 port%0d: actual wr=%b hit=%b data=%h lat=%0d expected wr=%b hit=%b data=%h lat=5",
               rq, p, rsp_wr[p], rsp_hit[p], rsp_data[p], cyc - int'(e.cyc), e.wr, e.hit, e.data);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rsp_vld[0]) take(0);
      if (rsp_vld[1]) take(1);
    end
  end

  initial begin
    for (int s = 0; s < 4; s++)
      for (int k = 0; k < 4; k++) begin
        mtag[s][k] = '0; mval[s][k] = 1'b0;
        mdat[0][s][k] = '0; mdat[1][s][k] = '0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    nchk++;
    if (rsp_vld !== 2'b00 || req_rdy !== 2'b11) begin
      nfail++;
      $display("FAIL R9 reset: actual vld=%b rdy=%b expected vld=00 rdy=11", rsp_vld, req_rdy);
    end

    // R9/R6: everything misses after reset; R2: both banks per cycle
    for (int i = 0; i < 32; i++)
      drive(1, 0, {5'(i), 1'b0}, '0, 1, 0, {5'(i), 1'b1}, '0, "R9/R6/R2");

    // R10: four distinct tags per set
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 4; w++) install(s, (2 * w + s) & 7, w);
    repeat (2) @(negedge clk);

    // R1/R5/R6: write every address, ports swapped on odd steps
    for (int i = 0; i < 32; i++)
      if (i % 2 == 0)
        drive(1, 1, {5'(i), 1'b0}, pat({5'(i), 1'b0}, 1),
              1, 1, {5'(i), 1'b1}, pat({5'(i), 1'b1}, 1), "R1/R5/R6 write");
      else
        drive(1, 1, {5'(i), 1'b1}, pat({5'(i), 1'b1}, 1),
              1, 1, {5'(i), 1'b0}, pat({5'(i), 1'b0}, 1), "R1/R5/R6 write");
    for (int i = 0; i < 32; i++)
      drive(1, 0, {5'(31 - i), 1'(i)}, '0, 1, 0, {5'(31 - i), 1'(~i)}, '0, "R1/R5/R10 read");

    // R3: same-bank collisions, port 1 resubmitted next cycle
    for (int i = 0; i < 16; i++) begin
      logic [5:0] a0 = {5'(i), 1'(i)};
      logic [5:0] a1 = {5'(i + 7), 1'(i)};
      drive(1, (i % 3 == 0), a0, pat(a0, 2), 1, 0, a1, '0, "R3 clash");
      drive(0, 0, '0, '0, 1, 0, a1, '0, "R3 retry");
    end

    // R7: back-to-back mixed accesses on one bank, no gaps
    begin
      logic [5:0] a = mk(4, 2, 1);
      logic [5:0] o = mk(3, 3, 0);
      drive(1, 1, a, pat(a, 3), 0, 0, '0, '0, "R7 wr");
      drive(1, 0, a, '0, 0, 0, '0, '0, "R7 rd-after-wr");
      drive(0, 0, '0, '0, 1, 1, a, pat(a, 4), "R7 wr p1");
      drive(0, 0, '0, '0, 1, 0, a, '0, "R7 rd p1");
      drive(1, 1, a, pat(a, 5), 1, 0, o, '0, "R7 wr+other");
      drive(1, 0, a, '0, 1, 1, o, pat(o, 5), "R7 rd+wr");
      drive(1, 0, o, '0, 1, 0, a, '0, "R7 rd both");
    end
    repeat (7) @(negedge clk);

    // R8: move tag 1 of set 1 from way 0 into way 2
    install(1, 1, 2);
    repeat (2) @(negedge clk);
    drive(1, 0, mk(1, 1, 0), '0, 1, 0, mk(1, 1, 1), '0, "R8 moved tag hits");
    drive(1, 0, mk(5, 1, 0), '0, 1, 0, mk(5, 1, 1), '0, "R8 evicted tag misses");
    drive(1, 1, mk(1, 1, 1), pat(6, 6), 1, 1, mk(5, 1, 0), pat(7, 7), "R8/R6 write");
    drive(1, 0, mk(5, 1, 0), '0, 1, 0, mk(1, 1, 1), '0, "R8/R6 readback");
    install(1, 5, 0);
    repeat (2) @(negedge clk);
    drive(1, 0, mk(5, 1, 0), '0, 1, 0, mk(5, 1, 1), '0, "R8 way0 data kept");

    repeat (8) @(negedge clk);
    nchk++;
    if (eq0.size() != 0 || eq1.size() != 0) begin
      nfail++;
      $display("FAIL R4 drain: actual pending=%0d/%0d expected=0/0", eq0.size(), eq1.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++; nfail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

endmodule